// File: doc/BRIEF.md
# Constant-Latency Trigger Pipeline Buffer

This block holds one detector sample word per bunch-crossing clock in a circular store while a constant-latency trigger reaches its decision. The nominal trigger latency is fixed at elaboration. Cable skew means a decision can arrive up to 15 cycles ahead of its nominal time. A calibrated skew value therefore holds each decision back by that many cycles before it is used.

On an accept, the sample that the decision refers to is presented on the output for one cycle, marked by a valid strobe. A reject, or a cycle with no decision, produces nothing. Writing and extraction run on the same clock, so no retiming is needed at the output.

The skew value is captured only while reset is held. Decisions whose extraction would reach back before the first written sample are ignored, so no stale contents ever leave the block.

Top module: `trig_latency_buffer`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `out_valid` is 0 and `out_data` is all zeros.
- R2: With a skew value of 0, an accepting decision (`dec_valid`=1, `dec_accept`=1) sampled at clock edge c sets `out_valid` for the cycle after edge c. In that cycle `out_data` carries the sample written at edge c−160. Edges are counted from 0 at the first edge with reset released.
- R3: With a skew value D, an accepting decision sampled at edge c is applied at edge c+D. `out_valid` is set after that edge, and `out_data` carries the sample written at edge c−(160−D).
- R4: A rejecting decision (`dec_valid`=1, `dec_accept`=0), or a cycle with `dec_valid`=0, never sets `out_valid`. `out_data` keeps the last extracted sample until the next extraction.
- R5: Each accepting decision gives exactly one single-cycle `out_valid` pulse. Decisions on consecutive cycles give consecutive pulses, each with its own sample.
- R6: A decision whose application edge comes before edge 160 is ignored. The first decision that can extract is the one applied at edge 160, and it delivers the sample written at edge 0.
- R7: `cfg_skew` is captured only while `rst_n` is 0. Changes to it after reset have no effect on timing or data.
- R8: Extraction stays correct after the write pointer has wrapped the store several times.
- R9: The largest skew value, 15, delays the output by 15 cycles and uses a read tap of 145.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock for writing and extraction |
| rst_n | input | 1 | Synchronous active-low reset; `cfg_skew` is loaded while it is low |
| cfg_skew | input | 4 | Decision delay in cycles (0 to 15) |
| smp_data | input | 16 | Sample written on every clock out of reset |
| dec_valid | input | 1 | A trigger decision is present this cycle |
| dec_accept | input | 1 | Decision value: 1 = accept, 0 = reject |
| out_valid | output | 1 | One-cycle strobe for an extracted sample |
| out_data | output | 16 | Extracted sample, held between extractions |

## Verification
An off-by-one in the write pointer, the read tap or the delay-line tap shows up on the very first extraction as a neighbouring sample's value. The bench writes a distinct value on every edge, so the error is visible at once. A wrong fill count shows as a strobe at edge 159 or a missing one at edge 160. A skew register that follows `cfg_skew` after reset moves the strobe by cycles, and this is seen within one decision. Corruption after the pointer wraps only appears after 256 writes, so the bench extracts well past that point.

// File: rtl/trig_latency_buffer.sv
module trig_latency_buffer #(
  parameter int DATA_W  = 16,
  parameter int LATENCY = 160,
  parameter int DEPTH   = 256,
  parameter int SKEW_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SKEW_W-1:0] cfg_skew,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              dec_valid,
  input  logic              dec_accept,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int AW       = $clog2(DEPTH);
  localparam int MAX_SKEW = (1 << SKEW_W) - 1;
  localparam int FILL_W   = $clog2(LATENCY + 1);

  logic [DATA_W-1:0]   store [DEPTH];
  logic [AW-1:0]       wr_ptr;
  logic [SKEW_W-1:0]   skew_q;
  logic [MAX_SKEW-1:0] dly_sr;
  logic [FILL_W-1:0]   fill_cnt;

  wire              take   = dec_valid & dec_accept;
  wire              armed  = (fill_cnt == FILL_W'(LATENCY));
  wire              hit    = (skew_q == '0) ? take : dly_sr[skew_q - 1'b1];
  wire              fire   = hit & armed;
  wire [AW-1:0]     rd_ptr = wr_ptr - AW'(LATENCY);

  always_ff @(posedge clk)
    if (rst_n) store[wr_ptr] <= smp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skew_q    <= cfg_skew;
      wr_ptr    <= '0;
      dly_sr    <= '0;
      fill_cnt  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      wr_ptr    <= wr_ptr + 1'b1;
      dly_sr    <= (dly_sr << 1) | MAX_SKEW'(take);
      if (!armed) fill_cnt <= fill_cnt + 1'b1;
      out_valid <= fire;
      if (fire) out_data <= store[rd_ptr];
    end
  end
endmodule

// File: rtl/trig_latency_buffer_chk.sv
module trig_latency_buffer_chk #(
  parameter int DATA_W  = 16,
  parameter int LATENCY = 160,
  parameter int SKEW_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dec_valid,
  input logic              dec_accept,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [SKEW_W-1:0] skew_q
);
  localparam int CW = $clog2(LATENCY + 2) + 1;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk)
    if (!rst_n) run_cnt <= '0;
    else if (run_cnt <= CW'(LATENCY)) run_cnt <= run_cnt + 1'b1;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!out_valid && out_data == '0));

  a_r6_no_stale_extract: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> run_cnt > CW'(LATENCY));

  a_r4_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  a_r7_skew_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(skew_q));

  a_r2_zero_skew_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && skew_q == '0) |-> $past(dec_valid && dec_accept));
endmodule

bind trig_latency_buffer trig_latency_buffer_chk #(
  .DATA_W(DATA_W), .LATENCY(LATENCY), .SKEW_W(SKEW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_accept(dec_accept),
  .out_valid(out_valid), .out_data(out_data), .skew_q(skew_q)
);

// File: tb/tb_trig_latency_buffer.sv
`timescale 1ns/1ps
module tb_trig_latency_buffer;
  localparam int LAT = 160;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_skew = '0;
  logic [15:0] smp_data = '0;
  logic        dec_valid = 1'b0;
  logic        dec_accept = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  int k = 0;
  int cur_d = 0;
  logic [15:0] last_data = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trig_latency_buffer dut (
    .clk(clk), .rst_n(rst_n), .cfg_skew(cfg_skew), .smp_data(smp_data),
    .dec_valid(dec_valid), .dec_accept(dec_accept),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [15:0] sdat(input int idx);
    return 16'(idx * 7 + 257);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", req, k - 1, act, exp);
    end
  endtask

  task automatic tick(input bit v, input bit a);
    smp_data   = sdat(k);
    dec_valid  = v;
    dec_accept = a;
    @(posedge clk);
    k++;
    @(negedge clk);
    dec_valid  = 1'b0;
    dec_accept = 1'b0;
  endtask

  task automatic do_reset(input int d);
    rst_n = 1'b0;
    cfg_skew = 4'(d);
    cur_d = d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    k = 0;
    last_data = '0;
  endtask

  task automatic idle_to(input int n);
    while (k < n) tick(0, 0);
  endtask

  task automatic decide(input bit acc, input bit fire, input string req);
    int c;
    logic [15:0] want;
    c = k;
    want = sdat(c - (LAT - cur_d));
    for (int j = 0; j <= cur_d; j++) begin
      bit ev;
      if (j == 0) tick(1, acc); else tick(0, 0);
      ev = fire && (j == cur_d);
      chk(out_valid == ev, req, out_valid, ev);
      if (ev) chk(out_data == want, req, out_data, want);
      else    chk(out_data == last_data, "R4", out_data, last_data);
    end
    if (fire) last_data = want;
    tick(0, 0);
    chk(out_valid == 1'b0, "R5", out_valid, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(out_data == 16'h0, "R1", out_data, 0);
    do_reset(0);
    tick(0, 0);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(out_data == 16'h0, "R1", out_data, 0);
  endtask

  task automatic t_fill_zero_skew;
    do_reset(0);
    idle_to(100);
    decide(1, 0, "R6");
    idle_to(159);
    decide(1, 0, "R6");
    decide(1, 1, "R2");
    decide(0, 0, "R4");
    decide(1, 1, "R2");
  endtask

  task automatic t_skew_boundary;
    do_reset(5);
    idle_to(154);
    decide(1, 0, "R6");
    do_reset(5);
    idle_to(155);
    decide(1, 1, "R6");
    idle_to(190);
    decide(1, 1, "R3");
    decide(0, 0, "R4");
  endtask

  task automatic t_max_skew;
    do_reset(15);
    idle_to(200);
    decide(1, 1, "R9");
    decide(1, 1, "R9");
  endtask

  task automatic t_cfg_ignored;
    do_reset(3);
    tick(0, 0);
    cfg_skew = 4'd9;
    idle_to(170);
    decide(1, 1, "R7");
    cfg_skew = 4'd0;
    decide(1, 1, "R7");
  endtask

  task automatic t_back_to_back;
    bit pat [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
    int c0;
    do_reset(2);
    idle_to(170);
    c0 = k;
    for (int i = 0; i < 7; i++) begin
      bit ev;
      if (i < 4) tick(1, pat[i]); else tick(0, 0);
      ev = (i >= 2) && (i - 2 < 4) && pat[i - 2];
      chk(out_valid == ev, "R5", out_valid, ev);
      if (ev) begin
        last_data = sdat(c0 + i - 2 - (LAT - 2));
        chk(out_data == last_data, "R5", out_data, last_data);
      end else begin
        chk(out_data == last_data, "R4", out_data, last_data);
      end
    end
  endtask

  task automatic t_wrap;
    idle_to(600);
    decide(1, 1, "R8");
    idle_to(1000);
    decide(1, 1, "R8");
    decide(0, 0, "R8");
  endtask

  initial begin
    t_reset();
    t_fill_zero_skew();
    t_skew_boundary();
    t_max_skew();
    t_cfg_ignored();
    t_back_to_back();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule